// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes one binary floating-point operand and rounds it to an integral value. The result stays in the same floating-point format. The exponent and fraction widths are parameters, so one body of code serves both the 32-bit format (8-bit exponent, 23-bit fraction) and the 64-bit format (11-bit exponent, 52-bit fraction). The rounding direction is chosen per operation by a 2-bit mode input. Two enable inputs decide whether an invalid condition or an inexact condition becomes a trap or only raises a flag.

Each operation is handled in one of four ways:
- Infinities and NaNs go through the special-value path.
- Operands that are already integral pass straight through.
- Operands with a fractional part but a magnitude of at least one are shifted, rounded and rebuilt.
- Magnitudes below one collapse to a signed zero or to a signed one.

The result, a write enable, one-cycle flag pulses and an exception code are registered one cycle after the operand is accepted. They stay on the outputs until the consumer takes them.

Top module: `fp_round_integral`

## Requirements
- R1: An operand is accepted when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. The outputs appear with `out_valid` high at the next clock edge. While `out_valid` is high and `out_ready` is low, all outputs hold steady. After reset, `out_valid` is low and `in_ready` is high.
- R2: Mode encoding: 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 rounds toward plus infinity, 11 rounds toward minus infinity.
- R3: An infinity or a quiet NaN (exponent all ones, fraction MSB set or fraction zero) is returned unchanged. No flag is raised, the exception code is 00 and `wr_en` is 1.
- R4: A signaling NaN has an all-ones exponent, a clear fraction MSB and a nonzero fraction. When the invalid trap is disabled, it is returned with the fraction MSB set, `flag_invalid` is 1 and `wr_en` is 1.
- R5: A signaling NaN with the invalid trap enabled gives exception code 01, `wr_en` 0 and `flag_invalid` 0.
- R6: An operand whose unbiased exponent is at least FRAC_W is returned unchanged with no flags.
- R7: An operand with an unbiased exponent from 0 to FRAC_W-1 and no nonzero discarded fraction bits is returned unchanged, with `flag_inexact` 0.
- R8: The directed modes act on the truncated magnitude. Toward plus infinity adds one unit only for positive operands. Toward minus infinity adds one unit only for negative operands. Toward zero never adds.
- R9: Round to nearest adds one unit when the highest discarded bit is set and either a lower discarded bit or the LSB of the truncated value is set.
- R10: When adding one unit carries past the hidden-one position, the result exponent field is one above the operand's exponent field and the fraction is zero.
- R11: For a magnitude below one that is not zero (exponent field below the bias), the result keeps the sign. It is ±1.0 (exponent field equal to the bias, fraction zero) in the directed mode that rounds away from zero for that sign. Otherwise it is a signed zero.
- R12: In round-to-nearest mode a below-one magnitude gives ±1.0 only when the exponent field is bias-1 and the fraction is nonzero. Exactly 0.5 gives zero. An exact zero gives the same zero with no flag.
- R13: Any inexact result is written (`wr_en` 1). With the inexact trap enabled, the exception code is 10 and `flag_inexact` is 0. With the trap disabled, the exception code is 00 and `flag_inexact` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can accept an operand |
| op | input | 1+EXP_W+FRAC_W | Operand: sign, exponent field, fraction |
| rmode | input | 2 | Rounding mode (R2 encoding) |
| trap_inv_en | input | 1 | Invalid trap enable |
| trap_inx_en | input | 1 | Inexact trap enable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 1+EXP_W+FRAC_W | Rounded value |
| wr_en | output | 1 | Result should be written to the destination |
| flag_invalid | output | 1 | Invalid flag pulse |
| flag_inexact | output | 1 | Inexact flag pulse |
| exc_code | output | 2 | 00 none, 01 invalid trap, 10 inexact trap |

## Verification
The assertions assume that the consumer reads the output fields only while `out_valid` is high. They also assume that `out_ready` is a free input that may stay low for any length of time. The properties therefore check the hold behaviour and the relations between `wr_en`, the flags and the exception code, and only in cycles where a result is present. The stimulus drives operands only while `in_ready` is high and keeps `in_valid` low between vectors. It includes one deliberate stall with `out_ready` low for several cycles, which exercises the hold condition.

// File: rtl/fpri_pkg.sv
package fpri_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    EXC_NONE     = 2'b00,
    EXC_INV_TRAP = 2'b01,
    EXC_INX_TRAP = 2'b10
  } exc_e;

  typedef enum logic [1:0] {
    CLS_SPECIAL,
    CLS_INTEGRAL,
    CLS_MIXED,
    CLS_BELOW_ONE
  } opclass_e;
endpackage

// File: rtl/fpri_unpack.sv
module fpri_unpack
  import fpri_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W-1:0]     frac_f,
  output opclass_e              cls,
  output logic                  is_snan
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W:0] INT_LIMIT = (EXP_W + 1)'(BIAS + FRAC_W);
  localparam logic [EXP_W-1:0] BIAS_F = EXP_W'(BIAS);

  assign sign   = op[EXP_W+FRAC_W];
  assign exp_f  = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    is_snan = 1'b0;
    if (&exp_f) begin
      cls     = CLS_SPECIAL;
      is_snan = !frac_f[FRAC_W-1] && (|frac_f);
    end else if ({1'b0, exp_f} >= INT_LIMIT) begin
      cls = CLS_INTEGRAL;
    end else if (exp_f >= BIAS_F) begin
      cls = CLS_MIXED;
    end else begin
      cls = CLS_BELOW_ONE;
    end
  end
endmodule

// File: rtl/fpri_frac_round.sv
module fpri_frac_round
  import fpri_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  sign,
  input  logic [EXP_W-1:0]      exp_f,
  input  logic [FRAC_W-1:0]     frac_f,
  input  logic [1:0]            rmode,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  inexact
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int P    = FRAC_W + 1;
  localparam int SHW  = $clog2(P + 1);
  localparam logic [SHW-1:0] FRAC_SH = SHW'(FRAC_W);
  localparam logic [P:0] ALL1 = {(P + 1){1'b1}};
  localparam logic [P:0] ONE  = (P + 1)'(1);

  logic [P:0]       sig, trunc, rounded, back;
  logic [EXP_W-1:0] ue;
  logic [SHW-1:0]   sh;
  logic             rbit, sticky, inc, carry;

  always_comb begin
    sig     = {1'b0, 1'b1, frac_f};
    ue      = exp_f - EXP_W'(BIAS);
    sh      = FRAC_SH - ue[SHW-1:0];
    trunc   = sig >> sh;
    inexact = |(sig & ~(ALL1 << sh));
    rbit    = |(sig & (ONE << (sh - 1'b1)));
    sticky  = |(sig & ~(ALL1 << (sh - 1'b1)));
    inc     = 1'b0;
    if (inexact) begin
      unique case (rmode_e'(rmode))
        RM_NEAREST: inc = rbit && (sticky || trunc[0]);
        RM_ZERO:    inc = 1'b0;
        RM_UP:      inc = !sign;
        RM_DOWN:    inc = sign;
      endcase
    end
    rounded = trunc + (P + 1)'(inc);
    back    = rounded << sh;
    carry   = back[P];
    res     = {sign, carry ? exp_f + 1'b1 : exp_f, back[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpri_below_one.sv
module fpri_below_one
  import fpri_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  sign,
  input  logic [EXP_W-1:0]      exp_f,
  input  logic [FRAC_W-1:0]     frac_f,
  input  logic [1:0]            rmode,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  inexact
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] ONE_EXP  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] HALF_EXP = EXP_W'(BIAS - 1);

  logic to_one;

  always_comb begin
    inexact = (|exp_f) || (|frac_f);
    to_one  = 1'b0;
    if (inexact) begin
      unique case (rmode_e'(rmode))
        RM_NEAREST: to_one = (exp_f == HALF_EXP) && (|frac_f);
        RM_ZERO:    to_one = 1'b0;
        RM_UP:      to_one = !sign;
        RM_DOWN:    to_one = sign;
      endcase
    end
    res = {sign, to_one ? ONE_EXP : '0, {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral
  import fpri_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic [1:0]            rmode,
  input  logic                  trap_inv_en,
  input  logic                  trap_inx_en,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  wr_en,
  output logic                  flag_invalid,
  output logic                  flag_inexact,
  output logic [1:0]            exc_code
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic              sign, is_snan;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  opclass_e          cls;
  logic [W-1:0]      mix_res, low_res, nxt_res;
  logic              mix_inx, low_inx, nxt_inx, nxt_inv;
  logic              accept;

  fpri_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .op(op), .sign(sign), .exp_f(exp_f), .frac_f(frac_f),
    .cls(cls), .is_snan(is_snan)
  );

  fpri_frac_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_frac (
    .sign(sign), .exp_f(exp_f), .frac_f(frac_f), .rmode(rmode),
    .res(mix_res), .inexact(mix_inx)
  );

  fpri_below_one #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_low (
    .sign(sign), .exp_f(exp_f), .frac_f(frac_f), .rmode(rmode),
    .res(low_res), .inexact(low_inx)
  );

  always_comb begin
    nxt_res = op;
    nxt_inx = 1'b0;
    nxt_inv = 1'b0;
    unique case (cls)
      CLS_SPECIAL: begin
        nxt_inv = is_snan;
        if (is_snan) nxt_res[FRAC_W-1] = 1'b1;
      end
      CLS_INTEGRAL: nxt_res = op;
      CLS_MIXED: begin
        nxt_res = mix_res;
        nxt_inx = mix_inx;
      end
      CLS_BELOW_ONE: begin
        nxt_res = low_res;
        nxt_inx = low_inx;
      end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      wr_en        <= 1'b0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      exc_code     <= EXC_NONE;
    end else if (accept) begin
      out_valid    <= 1'b1;
      result       <= nxt_res;
      wr_en        <= !(nxt_inv && trap_inv_en);
      flag_invalid <= nxt_inv && !trap_inv_en;
      flag_inexact <= nxt_inx && !trap_inx_en;
      if (nxt_inv && trap_inv_en)      exc_code <= EXC_INV_TRAP;
      else if (nxt_inx && trap_inx_en) exc_code <= EXC_INX_TRAP;
      else                             exc_code <= EXC_NONE;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fpri_checker.sv
module fpri_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  wr_en,
  input logic                  flag_invalid,
  input logic                  flag_inexact,
  input logic [1:0]            exc_code
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(exc_code) && $stable(wr_en));

  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_quiet_nan_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && flag_invalid |-> (&result[EXP_W+FRAC_W-1:FRAC_W]) && result[FRAC_W-1]);

  assert_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !wr_en |-> exc_code == 2'b01);

  assert_inx_trap_R13: assert property (@(posedge clk) disable iff (rst)
    out_valid && exc_code == 2'b10 |-> wr_en && !flag_inexact);

  assert_one_event_R13: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({flag_invalid, flag_inexact, exc_code != 2'b00}));
endmodule

bind fp_round_integral fpri_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpri_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .result(result),
  .wr_en(wr_en), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
  .exc_code(exc_code)
);

// File: tb/test_fp_round_integral.sv
module test_fp_round_integral;
  localparam int NV = 30;
  // {req, op, mode, trap_inv, trap_inx, result, wr, finv, finx, exc}
  localparam logic [80:0] VEC [NV] = '{
    {8'd7,  32'h3F800000, 2'd0, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b0, 2'd0}, // R7 1.0
    {8'd9,  32'h3FC00000, 2'd0, 1'b0, 1'b0, 32'h40000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R9 1.5 -> 2
    {8'd9,  32'h40200000, 2'd0, 1'b0, 1'b0, 32'h40000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R9 2.5 -> 2
    {8'd10, 32'h40600000, 2'd0, 1'b0, 1'b0, 32'h40800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R10 3.5 -> 4
    {8'd9,  32'h3FA00000, 2'd0, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R9 1.25 -> 1
    {8'd8,  32'h3FC00000, 2'd1, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R8 R2 zero
    {8'd8,  32'h3FC00000, 2'd2, 1'b0, 1'b0, 32'h40000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R8 up
    {8'd8,  32'h3FC00000, 2'd3, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R8 down
    {8'd8,  32'hBFC00000, 2'd2, 1'b0, 1'b0, 32'hBF800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R8 -1.5 up
    {8'd8,  32'hBFC00000, 2'd3, 1'b0, 1'b0, 32'hC0000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R8 -1.5 down
    {8'd10, 32'h3FE00000, 2'd2, 1'b0, 1'b0, 32'h40000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R10 1.75 up
    {8'd10, 32'h4AFFFFFF, 2'd0, 1'b0, 1'b0, 32'h4B000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R10 top carry
    {8'd12, 32'h3F000000, 2'd0, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R12 0.5 -> 0
    {8'd12, 32'h3F400000, 2'd0, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R12 0.75
    {8'd12, 32'h3E800000, 2'd0, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R12 0.25
    {8'd12, 32'hBF400000, 2'd0, 1'b0, 1'b0, 32'hBF800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R12 -0.75
    {8'd11, 32'h3E800000, 2'd2, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R11 0.25 up
    {8'd11, 32'hBE800000, 2'd2, 1'b0, 1'b0, 32'h80000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R11 -0.25 up
    {8'd11, 32'hBE800000, 2'd3, 1'b0, 1'b0, 32'hBF800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R11 -0.25 down
    {8'd11, 32'h3F400000, 2'd1, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b1, 2'd0}, // R11 zero mode
    {8'd12, 32'h80000000, 2'd3, 1'b0, 1'b0, 32'h80000000, 1'b1, 1'b0, 1'b0, 2'd0}, // R12 exact -0
    {8'd11, 32'h00000001, 2'd2, 1'b0, 1'b0, 32'h3F800000, 1'b1, 1'b0, 1'b1, 2'd0}, // R11 denormal
    {8'd6,  32'h4B000001, 2'd0, 1'b0, 1'b0, 32'h4B000001, 1'b1, 1'b0, 1'b0, 2'd0}, // R6
    {8'd6,  32'h4B800000, 2'd2, 1'b0, 1'b0, 32'h4B800000, 1'b1, 1'b0, 1'b0, 2'd0}, // R6
    {8'd3,  32'h7F800000, 2'd0, 1'b0, 1'b0, 32'h7F800000, 1'b1, 1'b0, 1'b0, 2'd0}, // R3 +inf
    {8'd3,  32'hFF800000, 2'd1, 1'b0, 1'b0, 32'hFF800000, 1'b1, 1'b0, 1'b0, 2'd0}, // R3 -inf
    {8'd3,  32'h7FC00000, 2'd0, 1'b1, 1'b0, 32'h7FC00000, 1'b1, 1'b0, 1'b0, 2'd0}, // R3 qNaN
    {8'd4,  32'h7F800001, 2'd0, 1'b0, 1'b0, 32'h7FC00001, 1'b1, 1'b1, 1'b0, 2'd0}, // R4 sNaN
    {8'd5,  32'h7F800001, 2'd0, 1'b1, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 2'd1}, // R5 trap
    {8'd13, 32'h3FC00000, 2'd0, 1'b0, 1'b1, 32'h40000000, 1'b1, 1'b0, 1'b0, 2'd2}  // R13 trap
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, trap_inv_en = 1'b0, trap_inx_en = 1'b0, out_ready = 1'b1;
  logic [31:0] op = '0;
  logic [1:0]  rmode = '0;
  logic        in_ready, out_valid, wr_en, flag_invalid, flag_inexact;
  logic [31:0] result;
  logic [1:0]  exc_code;
  int          n_run = 0, n_fail = 0, cycles = 0;
  logic [31:0] held;

  always #2 clk = ~clk;

  fp_round_integral i_fp_round_integral (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .rmode(rmode), .trap_inv_en(trap_inv_en), .trap_inx_en(trap_inx_en),
    .out_valid(out_valid), .out_ready(out_ready), .result(result), .wr_en(wr_en),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact), .exc_code(exc_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op = VEC[i][72:41];
      rmode = VEC[i][40:39];
      trap_inv_en = VEC[i][38];
      trap_inx_en = VEC[i][37];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d valid #%0d", VEC[i][80:73], i), {31'd0, out_valid}, 32'd1);
      if (VEC[i][4])
        check($sformatf("R%0d result #%0d", VEC[i][80:73], i), result, VEC[i][36:5]);
      check($sformatf("R%0d status #%0d", VEC[i][80:73], i),
            {27'd0, wr_en, flag_invalid, flag_inexact, exc_code}, {27'd0, VEC[i][4:0]});
      @(negedge clk);
    end

    // R1 stall: result held while out_ready is low
    out_ready = 1'b0;
    op = 32'h40200000; rmode = 2'd2; trap_inv_en = 1'b0; trap_inx_en = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    op = 32'h3F800000;
    held = result;
    check("R1 stalled result", result, 32'h40400000);
    repeat (3) @(negedge clk);
    check("R1 hold result", result, held);
    check("R1 hold valid", {31'd0, out_valid}, 32'd1);
    check("R1 ready low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 next accepted", result, 32'h3F800000);
    @(negedge clk);
    check("R1 drain", {31'd0, out_valid}, 32'd0);

    finish_run();
  end
endmodule